// File: doc/BRIEF.md
# Command-Queue I2C Controller Engine

This block runs I2C controller-side transactions from a queue of command words. Software, or a neighbouring engine, writes each command into a transmit queue. A command carries one byte of write data or a request to read one byte, an optional end-of-transaction flag, and an optional address-only marker. When enabled, the engine takes the first queued command and generates a START. It then sends the latched target address with the R/W bit and shifts bytes out or in, one command per byte. Received bytes are collected in a receive queue.

When the direction of the next command differs from the current one, the engine generates a repeated START by itself and resends the address. A NACK from the target ends the transaction with a STOP, discards the commands that remain, and records which phase failed. The line timing comes from an external strobe. Each strobe advances one quarter of a bit cell. The bus is driven only through open-drain style pull-low outputs.

Top module: `i2c_cmd_master`

## Requirements
- R1: Every transaction starts with START, then the 7-bit target address MSB first and the R/W bit (1 = read), then an acknowledge bit; every data byte is sent MSB first and followed by an acknowledge bit; SDA only changes while SCL is low, except inside START, repeated START and STOP.
- R2: In a command word, bit 8 = 1 requests a one-byte read, bit 8 = 0 a write of bits [7:0]; bit 9 = 1 makes the engine issue STOP once that byte and its acknowledge are done.
- R3: When the next command's direction differs from the previous byte of the same transaction, a repeated START is issued, followed by the address with the new R/W bit; the target address is captured when the transaction starts and reused for every repeated START.
- R4: During a read the engine drives ACK (SDA low) after each byte, except on a command with bit 9 set, where it leaves SDA high (NACK) before STOP; received bytes appear in order on `rx_data` and each `rx_rd` pulse removes one.
- R5: `status` bit 0 = engine or bus sequencer active, 1 = TX queue not full, 2 = TX queue empty, 3 = RX queue not empty, 4 = RX queue full, 5 = transaction in progress.
- R6: `raw_irq` bit 0 (stop seen) sets when a STOP completes; any `raw_irq` bit is cleared by a one-cycle pulse on the same bit of `clr_irq`.
- R7: A NACK on the address or on a written byte discards all queued TX commands, issues STOP, sets `raw_irq` bit 1, and sets `abort_src` to 1 for address or 2 for data.
- R8: A command with bit 10 set performs only the address phase (write direction), then STOP, with no data byte.
- R9: No transaction starts while `enable` is low; `enable_status` goes high the cycle after `enable` rises, and after `enable` falls it drops only once the transaction in progress has ended.
- R10: Both queues hold TX_DEPTH / RX_DEPTH (default 16) entries; a write to a full TX queue is dropped and sets `raw_irq` bit 2; a read of an empty RX queue sets `raw_irq` bit 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Controller enable |
| target_addr | input | 7 | Target device address |
| cmd_wr | input | 1 | Push `cmd_word` into the TX queue |
| cmd_word | input | 11 | Command: [7:0] data, [8] read, [9] stop, [10] address-only |
| rx_rd | input | 1 | Pop one byte from the RX queue |
| rx_data | output | 8 | Oldest received byte |
| status | output | 6 | Status flags (see R5) |
| raw_irq | output | 4 | Sticky events: stop, abort, TX overflow, RX underflow |
| clr_irq | input | 4 | Per-bit clear strobes for `raw_irq` |
| abort_src | output | 2 | Cause of last abort: 1 address NACK, 2 data NACK |
| enable_status | output | 1 | Delayed enable state |
| scl_tick | input | 1 | Quarter-bit timing strobe |
| sda_in | input | 1 | Sampled SDA line level |
| scl_low | output | 1 | Pull SCL low |
| sda_low | output | 1 | Pull SDA low |

## Verification
The bench attaches a behavioural target on the wires. It goes after the write-then-read switch: an engine that forgets the repeated START, or keeps the old R/W bit, produces a byte sequence that the scoreboard rejects. Address NACK and data NACK are both provoked while more commands wait in the queue. A missing flush would show up as a non-empty TX queue or extra bus bytes, and a swapped cause code as a wrong `abort_src`. The last read byte must carry a NACK, or the target would hold SDA and the STOP would vanish. Dropping `enable` in the middle of a transfer must leave `enable_status` high until the STOP.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
   localparam int ADDR_W  = 7;
   localparam int CMD_W   = 11;
   localparam int CB_RD   = 8;
   localparam int CB_STOP = 9;
   localparam int CB_BARE = 10;

   localparam logic [1:0] ABT_NONE = 2'd0;
   localparam logic [1:0] ABT_ADDR = 2'd1;
   localparam logic [1:0] ABT_DATA = 2'd2;

   typedef enum logic [1:0] {BOP_START, BOP_RSTART, BOP_STOP, BOP_BIT} bus_op_e;

   typedef enum logic [2:0] {
      SQ_IDLE, SQ_START, SQ_ADDR, SQ_DATA, SQ_NEXT, SQ_FLUSH, SQ_STOP
   } seq_st_e;
endpackage

// File: rtl/i2cm_fifo.sv
module i2cm_fifo #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] din,
   input  logic             pop,
   output logic [WIDTH-1:0] dout,
   output logic             empty,
   output logic             full
);
   localparam int  AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int  CW   = $clog2(DEPTH + 1);
   localparam bit  POW2 = ((1 << AW) == DEPTH);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("i2cm_fifo: DEPTH must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("i2cm_fifo: WIDTH must be positive");
      end
   endgenerate

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wp, rp, wp_nx, rp_nx;
   logic [CW-1:0]    cnt;
   logic             do_push, do_pop;

   generate
      if (POW2) begin : g_pow2
         assign wp_nx = wp + 1'b1;
         assign rp_nx = rp + 1'b1;
      end else begin : g_wrap
         assign wp_nx = (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
         assign rp_nx = (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      end
   endgenerate

   assign empty   = (cnt == '0);
   assign full    = (cnt == CW'(DEPTH));
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = mem[rp];

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (do_push) wp <= wp_nx;
         if (do_pop)  rp <= rp_nx;
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   // R10
   fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(DEPTH));
endmodule

// File: rtl/i2cm_bitphy.sv
module i2cm_bitphy
   import i2cm_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    tick,
   input  logic    go,
   input  bus_op_e op,
   input  logic    bitv,
   input  logic    sda_in,
   output logic    busy,
   output logic    done,
   output logic    rxbit,
   output logic    scl_low,
   output logic    sda_low
);
   bus_op_e    op_q;
   logic       bit_q;
   logic [1:0] ph;

   // returns {scl_low, sda_low} for one quarter of an operation
   function automatic logic [1:0] pat(bus_op_e o, logic [1:0] p, logic b);
      logic [1:0] r;
      case (o)
         BOP_START:  r = (p == 2'd0) ? 2'b00 : (p == 2'd3) ? 2'b11 : 2'b01;
         BOP_RSTART: r = (p == 2'd0) ? 2'b10 : (p == 2'd1) ? 2'b00 :
                         (p == 2'd2) ? 2'b01 : 2'b11;
         BOP_STOP:   r = (p == 2'd0) ? 2'b11 : (p == 2'd3) ? 2'b00 : 2'b01;
         default:    r = {(p == 2'd0) || (p == 2'd3), ~b};
      endcase
      return r;
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         done    <= 1'b0;
         rxbit   <= 1'b1;
         scl_low <= 1'b0;
         sda_low <= 1'b0;
         op_q    <= BOP_START;
         bit_q   <= 1'b1;
         ph      <= 2'd0;
      end else begin
         done <= 1'b0;
         if (go && !busy) begin
            busy  <= 1'b1;
            op_q  <= op;
            bit_q <= bitv;
            ph    <= 2'd0;
         end else if (busy && tick) begin
            {scl_low, sda_low} <= pat(op_q, ph, bit_q);
            if (ph == 2'd2) rxbit <= sda_in;
            if (ph == 2'd3) begin
               busy <= 1'b0;
               done <= 1'b1;
            end
            ph <= ph + 2'd1;
         end
      end
   end

   // R1
   sda_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && op_q == BOP_BIT && !scl_low) |=> $stable(sda_low));
endmodule

// File: rtl/i2cm_seq.sv
module i2cm_seq
   import i2cm_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic [ADDR_W-1:0] target_addr,
   input  logic [CMD_W-1:0]  head,
   input  logic              tx_empty,
   output logic              tx_pop,
   output logic              rx_push,
   output logic [7:0]        rx_byte,
   output logic              phy_go,
   output bus_op_e           phy_op,
   output logic              phy_bit,
   input  logic              phy_done,
   input  logic              phy_rxbit,
   output logic              busy,
   output logic              stop_evt,
   output logic              abort_evt,
   output logic [1:0]        abort_code
);
   seq_st_e           st;
   logic [7:0]        sh;
   logic [3:0]        cnt;
   logic              wt, cur_rd, cur_stop, dir_q;
   logic [ADDR_W-1:0] addr_q;

   assign busy    = (st != SQ_IDLE);
   assign rx_byte = sh;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st         <= SQ_IDLE;
         sh         <= '0;
         cnt        <= '0;
         wt         <= 1'b0;
         cur_rd     <= 1'b0;
         cur_stop   <= 1'b0;
         dir_q      <= 1'b0;
         addr_q     <= '0;
         tx_pop     <= 1'b0;
         rx_push    <= 1'b0;
         phy_go     <= 1'b0;
         phy_op     <= BOP_START;
         phy_bit    <= 1'b1;
         stop_evt   <= 1'b0;
         abort_evt  <= 1'b0;
         abort_code <= ABT_NONE;
      end else begin
         tx_pop    <= 1'b0;
         rx_push   <= 1'b0;
         phy_go    <= 1'b0;
         stop_evt  <= 1'b0;
         abort_evt <= 1'b0;
         case (st)
            SQ_IDLE: if (enable && !tx_empty) begin
               addr_q <= target_addr;
               dir_q  <= head[CB_RD] & ~head[CB_BARE];
               phy_op <= BOP_START;
               phy_go <= 1'b1;
               wt     <= 1'b1;
               st     <= SQ_START;
            end
            SQ_START: if (phy_done) begin
               sh  <= {addr_q, dir_q};
               cnt <= '0;
               wt  <= 1'b0;
               st  <= SQ_ADDR;
            end
            SQ_ADDR: if (!wt) begin
               phy_op  <= BOP_BIT;
               phy_bit <= (cnt < 4'd8) ? sh[7] : 1'b1;
               phy_go  <= 1'b1;
               wt      <= 1'b1;
            end else if (phy_done) begin
               wt <= 1'b0;
               if (cnt < 4'd8) begin
                  sh  <= {sh[6:0], 1'b0};
                  cnt <= cnt + 4'd1;
               end else if (phy_rxbit) begin
                  abort_code <= ABT_ADDR;
                  abort_evt  <= 1'b1;
                  st         <= SQ_FLUSH;
               end else begin
                  st <= SQ_NEXT;
               end
            end
            SQ_NEXT: if (!tx_empty) begin
               if (head[CB_BARE]) begin
                  tx_pop <= 1'b1;
                  st     <= SQ_STOP;
               end else if (head[CB_RD] != dir_q) begin
                  dir_q  <= head[CB_RD];
                  phy_op <= BOP_RSTART;
                  phy_go <= 1'b1;
                  wt     <= 1'b1;
                  st     <= SQ_START;
               end else begin
                  tx_pop   <= 1'b1;
                  cur_rd   <= head[CB_RD];
                  cur_stop <= head[CB_STOP];
                  sh       <= head[CB_RD] ? 8'h00 : head[7:0];
                  cnt      <= '0;
                  wt       <= 1'b0;
                  st       <= SQ_DATA;
               end
            end else if (!enable) begin
               st <= SQ_STOP;
            end
            SQ_DATA: if (!wt) begin
               phy_op  <= BOP_BIT;
               phy_bit <= (cnt < 4'd8) ? (cur_rd | sh[7]) : (cur_rd ? cur_stop : 1'b1);
               phy_go  <= 1'b1;
               wt      <= 1'b1;
            end else if (phy_done) begin
               wt <= 1'b0;
               if (cnt < 4'd8) begin
                  sh  <= {sh[6:0], cur_rd & phy_rxbit};
                  cnt <= cnt + 4'd1;
               end else if (cur_rd) begin
                  rx_push <= 1'b1;
                  st      <= cur_stop ? SQ_STOP : SQ_NEXT;
               end else if (phy_rxbit) begin
                  abort_code <= ABT_DATA;
                  abort_evt  <= 1'b1;
                  st         <= SQ_FLUSH;
               end else begin
                  st <= cur_stop ? SQ_STOP : SQ_NEXT;
               end
            end
            SQ_FLUSH: begin
               tx_pop <= !tx_pop && !tx_empty;
               if (tx_empty && !tx_pop) st <= SQ_STOP;
            end
            SQ_STOP: if (!wt) begin
               phy_op <= BOP_STOP;
               phy_go <= 1'b1;
               wt     <= 1'b1;
            end else if (phy_done) begin
               wt       <= 1'b0;
               stop_evt <= 1'b1;
               st       <= SQ_IDLE;
            end
            default: st <= SQ_IDLE;
         endcase
      end
   end

   // R6
   stop_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_evt |-> $past(st == SQ_STOP));
   // R7
   abort_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      abort_evt |-> (abort_code != ABT_NONE));
endmodule

// File: rtl/i2c_cmd_master.sv
module i2c_cmd_master
   import i2cm_pkg::*;
#(
   parameter int TX_DEPTH = 16,
   parameter int RX_DEPTH = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic [ADDR_W-1:0] target_addr,
   input  logic              cmd_wr,
   input  logic [CMD_W-1:0]  cmd_word,
   input  logic              rx_rd,
   output logic [7:0]        rx_data,
   output logic [5:0]        status,
   output logic [3:0]        raw_irq,
   input  logic [3:0]        clr_irq,
   output logic [1:0]        abort_src,
   output logic              enable_status,
   input  logic              scl_tick,
   input  logic              sda_in,
   output logic              scl_low,
   output logic              sda_low
);
   logic [CMD_W-1:0] tx_head;
   logic             tx_empty, tx_full, tx_pop;
   logic             rx_empty, rx_full, rx_push;
   logic [7:0]       rx_byte;
   logic             phy_go, phy_bit, phy_done, phy_rxbit, phy_busy;
   bus_op_e          phy_op;
   logic             seq_busy, stop_evt, abort_evt;
   logic [3:0]       irq_set;

   i2cm_fifo #(.WIDTH(CMD_W), .DEPTH(TX_DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n), .push(cmd_wr), .din(cmd_word),
      .pop(tx_pop), .dout(tx_head), .empty(tx_empty), .full(tx_full));

   i2cm_fifo #(.WIDTH(8), .DEPTH(RX_DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n), .push(rx_push), .din(rx_byte),
      .pop(rx_rd), .dout(rx_data), .empty(rx_empty), .full(rx_full));

   i2cm_seq u_seq (
      .clk(clk), .rst_n(rst_n), .enable(enable), .target_addr(target_addr),
      .head(tx_head), .tx_empty(tx_empty), .tx_pop(tx_pop),
      .rx_push(rx_push), .rx_byte(rx_byte),
      .phy_go(phy_go), .phy_op(phy_op), .phy_bit(phy_bit),
      .phy_done(phy_done), .phy_rxbit(phy_rxbit),
      .busy(seq_busy), .stop_evt(stop_evt), .abort_evt(abort_evt),
      .abort_code(abort_src));

   i2cm_bitphy u_phy (
      .clk(clk), .rst_n(rst_n), .tick(scl_tick), .go(phy_go), .op(phy_op),
      .bitv(phy_bit), .sda_in(sda_in), .busy(phy_busy), .done(phy_done),
      .rxbit(phy_rxbit), .scl_low(scl_low), .sda_low(sda_low));

   assign status = {seq_busy, rx_full, !rx_empty, tx_empty, !tx_full,
                    seq_busy | phy_busy};

   assign irq_set = {rx_rd & rx_empty, cmd_wr & tx_full, abort_evt, stop_evt};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         raw_irq       <= '0;
         enable_status <= 1'b0;
      end else begin
         for (int i = 0; i < 4; i++)
            raw_irq[i] <= irq_set[i] | (raw_irq[i] & ~clr_irq[i]);
         if (enable)         enable_status <= 1'b1;
         else if (!seq_busy) enable_status <= 1'b0;
      end
   end

   // R9
   en_fall_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(enable_status) |-> !$past(seq_busy));
   // R10
   tx_over_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(raw_irq[2]) |-> $past(cmd_wr && tx_full));
   // R5
   tx_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      status[2] |-> status[1]);
endmodule

// File: tb/i2c_cmd_master_tb_top.sv
module i2c_cmd_master_tb_top;
   localparam int EV_START = 1000;
   localparam int EV_STOP  = 2000;
   localparam logic [6:0] SLV = 7'h2A;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enable = 1'b0;
   logic [6:0]  target_addr = SLV;
   logic        cmd_wr = 1'b0;
   logic [10:0] cmd_word = '0;
   logic        rx_rd = 1'b0;
   logic [7:0]  rx_data;
   logic [5:0]  status;
   logic [3:0]  raw_irq;
   logic [3:0]  clr_irq = '0;
   logic [1:0]  abort_src;
   logic        enable_status;
   logic        scl_tick = 1'b0;
   logic        scl_low, sda_low;
   logic        s_low = 1'b0;
   logic        scl_bus, sda_bus;

   assign scl_bus = ~scl_low;
   assign sda_bus = ~(sda_low | s_low);

   i2c_cmd_master dut_i (
      .clk(clk), .rst_n(rst_n), .enable(enable), .target_addr(target_addr),
      .cmd_wr(cmd_wr), .cmd_word(cmd_word), .rx_rd(rx_rd), .rx_data(rx_data),
      .status(status), .raw_irq(raw_irq), .clr_irq(clr_irq),
      .abort_src(abort_src), .enable_status(enable_status),
      .scl_tick(scl_tick), .sda_in(sda_bus), .scl_low(scl_low),
      .sda_low(sda_low));

   always #5 clk = ~clk;

   int pass_cnt = 0;
   int fail_cnt = 0;
   int exp_q[$];

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      if (ok) pass_cnt++;
      else begin
         fail_cnt++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // bus event monitor: pops the scoreboard queue (R1)
   task automatic evt(input int v);
      if (exp_q.size() == 0) chk(1'b0, "R1", v, -1);
      else begin
         int e;
         e = exp_q.pop_front();
         chk(v == e, "R1", v, e);
      end
   endtask

   // quarter-bit strobe every second clock
   always @(negedge clk) scl_tick <= ~scl_tick;

   // behavioural target plus monitor
   logic       ps = 1'b1, pd = 1'b1;
   int         bc = 0;
   logic [7:0] sr = '0;
   logic [7:0] rd_val = 8'hA0;
   bit         is_addr = 0, rdm = 0, acc = 0;

   always @(negedge clk) begin
      logic sc, sd;
      sc = scl_bus;
      sd = sda_bus;
      if (rst_n) begin
         if (sc && ps && pd && !sd) begin
            evt(EV_START);
            bc = 0; is_addr = 1; rdm = 0; s_low = 0;
         end else if (sc && ps && !pd && sd) begin
            evt(EV_STOP);
            bc = 0; is_addr = 0; rdm = 0; s_low = 0;
         end else if (sc && !ps) begin
            if (bc < 8) sr = {sr[6:0], sd};
            else begin
               evt({23'd0, sd, sr});
               if (is_addr) begin
                  acc = (sr[7:1] == SLV);
                  rdm = acc && sr[0];
               end else if (rdm) begin
                  rd_val = rd_val + 8'd1;
                  if (sd) rdm = 0;
               end
            end
            bc++;
         end else if (!sc && ps) begin
            if (bc == 9) begin
               bc = 0; s_low = 0;
               if (is_addr) is_addr = 0;
            end
            if (bc == 8) begin
               if (is_addr) s_low = (sr[7:1] == SLV);
               else if (!rdm) s_low = acc && (sr != 8'hEE);
               else s_low = 0;
            end
            if (rdm && !is_addr && bc < 8) s_low = !rd_val[7 - bc];
         end
      end
      ps = sc;
      pd = sd;
   end

   task automatic push_cmd(input logic [10:0] w);
      @(negedge clk);
      cmd_wr = 1'b1; cmd_word = w;
      @(negedge clk);
      cmd_wr = 1'b0;
   endtask

   task automatic wait_idle();
      repeat (4) @(negedge clk);
      while (status[5] || !status[2]) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   task automatic clr(input logic [3:0] m);
      @(negedge clk); clr_irq = m;
      @(negedge clk); clr_irq = '0;
      @(negedge clk);
   endtask

   task automatic pop_rx(input logic [7:0] e);
      @(negedge clk);
      chk(rx_data == e, "R4", rx_data, e);
      rx_rd = 1'b1;
      @(negedge clk);
      rx_rd = 1'b0;
   endtask

   task automatic q_done(input string req);
      chk(exp_q.size() == 0, req, exp_q.size(), 0);
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", pass_cnt, pass_cnt + fail_cnt);
      $finish;
   endtask

   initial begin
      #1_000_000;
      chk(1'b0, "watchdog", 0, 1);
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R5 reset state: TX empty and not full only
      chk(status == 6'b000110, "R5", status, 6'b000110);
      chk(enable_status == 1'b0, "R9", enable_status, 0);
      chk(raw_irq == 4'b0, "R6", raw_irq, 0);
      chk({scl_low, sda_low} == 2'b00, "R1", {scl_low, sda_low}, 0);

      enable = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk(enable_status == 1'b1, "R9", enable_status, 1);

      // R2: two writes, stop on the last
      exp_q = '{EV_START, 'h054, 'h011, 'h022, EV_STOP};
      push_cmd(11'h011);
      push_cmd(11'h222);
      wait_idle();
      q_done("R2");
      chk(raw_irq[0] == 1'b1, "R6", raw_irq[0], 1);
      clr(4'b0001);
      chk(raw_irq[0] == 1'b0, "R6", raw_irq[0], 0);

      // R4: two reads, last NACKed
      exp_q = '{EV_START, 'h055, 'h0A0, 'h1A1, EV_STOP};
      push_cmd(11'h100);
      push_cmd(11'h300);
      wait_idle();
      q_done("R4");
      chk(status[3] == 1'b1, "R5", status[3], 1);
      pop_rx(8'hA0);
      pop_rx(8'hA1);
      @(negedge clk);
      chk(status[3] == 1'b0, "R5", status[3], 0);

      // R3: write then read gives a repeated START
      exp_q = '{EV_START, 'h054, 'h05A, EV_START, 'h055, 'h1A2, EV_STOP};
      push_cmd(11'h05A);
      push_cmd(11'h300);
      wait_idle();
      q_done("R3");
      pop_rx(8'hA2);

      // R8: address-only probe
      exp_q = '{EV_START, 'h054, EV_STOP};
      push_cmd(11'h600);
      wait_idle();
      q_done("R8");
      chk(raw_irq[1] == 1'b0, "R8", raw_irq[1], 0);

      // R7: address NACK flushes the queue
      target_addr = 7'h33;
      exp_q = '{EV_START, 'h166, EV_STOP};
      push_cmd(11'h001);
      push_cmd(11'h202);
      wait_idle();
      q_done("R7");
      chk(raw_irq[1] == 1'b1, "R7", raw_irq[1], 1);
      chk(abort_src == 2'd1, "R7", abort_src, 1);
      chk(status[2] == 1'b1, "R7", status[2], 1);
      clr(4'b0011);

      // R7: data NACK
      target_addr = SLV;
      exp_q = '{EV_START, 'h054, 'h1EE, EV_STOP};
      push_cmd(11'h0EE);
      push_cmd(11'h212);
      wait_idle();
      q_done("R7");
      chk(abort_src == 2'd2, "R7", abort_src, 2);
      chk(raw_irq[1] == 1'b1, "R7", raw_irq[1], 1);
      clr(4'b0011);

      // R9 / R10: disabled, fill the TX queue and overflow it
      enable = 1'b0;
      repeat (3) @(negedge clk);
      chk(enable_status == 1'b0, "R9", enable_status, 0);
      for (int i = 0; i < 16; i++) push_cmd(11'h0AB);
      repeat (20) @(negedge clk);
      chk(status[5] == 1'b0, "R9", status[5], 0);
      chk({scl_low, sda_low} == 2'b00, "R9", {scl_low, sda_low}, 0);
      chk(status[1] == 1'b0, "R10", status[1], 0);
      chk(raw_irq[2] == 1'b0, "R10", raw_irq[2], 0);
      push_cmd(11'h0CD);
      @(negedge clk);
      chk(raw_irq[2] == 1'b1, "R10", raw_irq[2], 1);
      target_addr = 7'h33;
      exp_q = '{EV_START, 'h166, EV_STOP};
      enable = 1'b1;
      wait_idle();
      q_done("R7");
      chk(status[2] == 1'b1, "R7", status[2], 1);
      clr(4'b0111);

      // R10: RX underflow
      @(negedge clk); rx_rd = 1'b1;
      @(negedge clk); rx_rd = 1'b0;
      @(negedge clk);
      chk(raw_irq[3] == 1'b1, "R10", raw_irq[3], 1);
      clr(4'b1000);
      chk(raw_irq[3] == 1'b0, "R6", raw_irq[3], 0);

      // R9: disable during a transfer
      target_addr = SLV;
      exp_q = '{EV_START, 'h054, 'h001, 'h002, EV_STOP};
      push_cmd(11'h001);
      push_cmd(11'h202);
      while (!status[5]) @(negedge clk);
      enable = 1'b0;
      repeat (30) @(negedge clk);
      chk(enable_status == 1'b1, "R9", enable_status, 1);
      wait_idle();
      q_done("R9");
      chk(enable_status == 1'b0, "R9", enable_status, 0);

      finish_run();
   end
endmodule